// File: doc/BRIEF.md
# 1-Wire ROM Search Sequencer

This block enumerates the devices on a 1-Wire bus by walking the binary tree of their 64-bit identifiers. Each search request returns one identifier. The block does not generate bus timing itself. It controls three lower-level primitives through request/acknowledge ports:

- a bus reset with presence detection;
- a byte write, which sends the search command;
- a triplet. A triplet reads one identifier bit and its complement, then writes a chosen branch direction. It reports both read bits and the direction that was actually taken.

The block keeps three items of state between requests: the position of the last unresolved branch, the last branch position inside the family byte, and a flag that marks the final device. With this state, a series of requests visits every device in turn. A completed identifier is accepted only if two conditions hold: its running CRC-8 over all eight bytes ends at zero, and its family byte (byte 0) is non-zero.

A host pulses `srch_start` and then waits for the one-cycle `srch_done`. When `srch_done` is high, `srch_ok`, `rom_id` and `fam_disc` give the result.

Top module: `ow_rom_search`

## Requirements
- R1: Every search that touches the bus begins with a reset request. If the reset returns no presence, the search fails, and the branch position, family position and final-device flag are all cleared.
- R2: After presence is seen, exactly one byte write carrying 8'hF0 is requested before the first triplet request.
- R3: For positions 1 to 64, the direction sent on the triplet depends on the stored branch position. Below it, the direction repeats the same bit of the previous identifier. At it, the direction is 1. Above it, the direction is 0. The direction stays stable while a triplet request waits for its acknowledge.
- R4: A triplet that returns both read bits as 1 ends the search at once with failure, and no further triplet is requested.
- R5: When both read bits are 0 and the taken direction is 0, that position becomes the last zero. If the position is 8 or less, it also becomes the reported family position (`fam_disc`), which therefore never exceeds 8.
- R6: The taken direction of position n is stored in `rom_id` bit n-1. This puts byte k in bits 8k+7..8k, least significant bit first, with the family byte in bits 7..0.
- R7: A search that processes all 64 bits succeeds only if the CRC-8 (reflected x^8+x^5+x^4+1, initial value 0, one byte at a time) over the eight bytes is zero. A CRC failure reports failure.
- R8: An identifier whose bits 7..0 are zero is reported as failure, and all search state is cleared, so the next search starts a fresh enumeration.
- R9: On success, the stored branch position becomes the last zero, and a last zero of 0 sets the final-device flag. A request made while the flag is set returns failure without any bus request and clears all search state. The request after that restarts the enumeration.
- R10: `srch_done` is high for exactly one cycle per request, with `srch_ok`, `rom_id` and `fam_disc` valid in that cycle. At most one primitive request is active at any time.
- R11: After reset, all outputs are zero and no primitive request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srch_start | input | 1 | One-cycle search request |
| srch_done | output | 1 | One-cycle completion pulse |
| srch_ok | output | 1 | Search succeeded, valid with srch_done |
| rom_id | output | 64 | Identifier found, byte 0 in the low bits |
| fam_disc | output | 7 | Last branch position inside the family byte, 0 if none |
| brst_req | output | 1 | Bus reset request, held until acknowledged |
| brst_ack | input | 1 | Bus reset finished |
| brst_presence | input | 1 | Presence seen, valid with brst_ack |
| wb_req | output | 1 | Byte write request |
| wb_data | output | 8 | Byte to write (search command) |
| wb_ack | input | 1 | Byte write finished |
| tri_req | output | 1 | Triplet request |
| tri_dir | output | 1 | Direction to write if the bus does not force one |
| tri_ack | input | 1 | Triplet finished, results valid |
| tri_bit | input | 1 | First read bit |
| tri_cmp | input | 1 | Complement read bit |
| tri_taken | input | 1 | Direction actually written |

## Verification
The bench builds the block with its default parameters: 8 identifier bytes, one family byte and a search command of 8'hF0. These are the values a real bus uses. With them, the bench model can emulate several wired-AND devices whose identifiers carry genuine CRC bytes. Four devices are chosen so that they split once inside the family byte (at position 4) and twice in the serial bytes. A complete four-device enumeration therefore covers the three direction cases, the family-position rule and the final-device flag within a few thousand cycles. Separate short runs cover the failure paths: an empty bus, a bus that asserts presence with no responding device, a zero family byte and a corrupted CRC byte.

// File: rtl/ow_rom_search.sv
module ow_rom_search #(
  parameter int          ID_BYTES   = 8,
  parameter int          FAM_BYTES  = 1,
  parameter logic [7:0]  SEARCH_CMD = 8'hF0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         srch_start,
  output logic                         srch_done,
  output logic                         srch_ok,
  output logic [ID_BYTES*8-1:0]        rom_id,
  output logic [$clog2(ID_BYTES*8+1)-1:0] fam_disc,
  output logic                         brst_req,
  input  logic                         brst_ack,
  input  logic                         brst_presence,
  output logic                         wb_req,
  output logic [7:0]                   wb_data,
  input  logic                         wb_ack,
  output logic                         tri_req,
  output logic                         tri_dir,
  input  logic                         tri_ack,
  input  logic                         tri_bit,
  input  logic                         tri_cmp,
  input  logic                         tri_taken
);
  localparam int ID_BITS = ID_BYTES * 8;
  localparam int PW      = $clog2(ID_BITS + 1);
  localparam int IW      = $clog2(ID_BITS);
  localparam logic [PW-1:0] FAM_LIM  = PW'(FAM_BYTES * 8 + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(ID_BITS - 1);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_CMD, S_TRIP, S_EVAL, S_DONE} st_t;
  st_t state;

  logic [PW-1:0]      bidx, last_disc, last_zero, fam_q;
  logic               last_dev, ok_q;
  logic [7:0]         crc, cur_byte;
  logic [ID_BITS-1:0] rom_q;

  function automatic logic [7:0] crc8_byte(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 8'h8C) : (r >> 1);
    return r;
  endfunction

  wire [PW-1:0] pos      = bidx + 1'b1;
  wire [7:0]    nxt_byte = {tri_taken, cur_byte[7:1]};
  wire          byte_end = (bidx[2:0] == 3'b111);

  assign tri_dir   = (pos < last_disc) ? rom_q[bidx[IW-1:0]] : (pos == last_disc);
  assign brst_req  = (state == S_RST);
  assign wb_req    = (state == S_CMD);
  assign tri_req   = (state == S_TRIP);
  assign wb_data   = SEARCH_CMD;
  assign srch_done = (state == S_DONE);
  assign srch_ok   = ok_q;
  assign rom_id    = rom_q;
  assign fam_disc  = fam_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      bidx      <= '0;
      last_disc <= '0;
      last_zero <= '0;
      fam_q     <= '0;
      last_dev  <= 1'b0;
      ok_q      <= 1'b0;
      crc       <= '0;
      cur_byte  <= '0;
      rom_q     <= '0;
    end else begin
      case (state)
        S_IDLE: if (srch_start) begin
          ok_q <= 1'b0;
          if (last_dev) begin
            last_disc <= '0;
            fam_q     <= '0;
            last_dev  <= 1'b0;
            state     <= S_DONE;
          end else begin
            bidx      <= '0;
            last_zero <= '0;
            crc       <= '0;
            state     <= S_RST;
          end
        end
        S_RST: if (brst_ack) begin
          if (brst_presence) state <= S_CMD;
          else begin
            last_disc <= '0;
            fam_q     <= '0;
            last_dev  <= 1'b0;
            state     <= S_DONE;
          end
        end
        S_CMD: if (wb_ack) state <= S_TRIP;
        S_TRIP: if (tri_ack) begin
          if (tri_bit && tri_cmp) begin
            last_disc <= '0;
            fam_q     <= '0;
            last_dev  <= 1'b0;
            state     <= S_DONE;
          end else begin
            if (!tri_bit && !tri_cmp && !tri_taken) begin
              last_zero <= pos;
              if (pos < FAM_LIM) fam_q <= pos;
            end
            rom_q[bidx[IW-1:0]] <= tri_taken;
            cur_byte <= nxt_byte;
            if (byte_end) crc <= crc8_byte(crc, nxt_byte);
            bidx <= bidx + 1'b1;
            if (bidx == LAST_IDX) state <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (crc == 8'h00 && rom_q[7:0] != 8'h00) begin
            ok_q      <= 1'b1;
            last_disc <= last_zero;
            last_dev  <= (last_zero == '0);
          end else begin
            last_disc <= '0;
            fam_q     <= '0;
            last_dev  <= 1'b0;
          end
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({brst_req, wb_req, tri_req}));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |=> !srch_done);
  p_cmd_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tri_req) |-> $past(wb_ack));
  p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tri_req && !tri_ack |=> tri_req && $stable(tri_dir));
  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tri_req && tri_ack && tri_bit && tri_cmp |=> srch_done && !srch_ok);
  p_fam_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fam_disc < FAM_LIM);
  p_zero_fam_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done && srch_ok |-> rom_id[7:0] != 8'h00);
  p_nobus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && srch_start && last_dev |=> srch_done && !srch_ok);
endmodule

// File: tb/sim_ow_rom_search.sv
module sim_ow_rom_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srch_start = 1'b0;
  logic        srch_done, srch_ok;
  logic [63:0] rom_id;
  logic [6:0]  fam_disc;
  logic        brst_req, wb_req, tri_req, tri_dir;
  logic [7:0]  wb_data;
  logic        brst_ack = 1'b0, brst_presence = 1'b0, wb_ack = 1'b0;
  logic        tri_ack = 1'b0, tri_bit = 1'b0, tri_cmp = 1'b0, tri_taken = 1'b0;

  always #10 clk = ~clk;

  ow_rom_search u0 (
    .clk(clk), .rst_n(rst_n), .srch_start(srch_start), .srch_done(srch_done),
    .srch_ok(srch_ok), .rom_id(rom_id), .fam_disc(fam_disc),
    .brst_req(brst_req), .brst_ack(brst_ack), .brst_presence(brst_presence),
    .wb_req(wb_req), .wb_data(wb_data), .wb_ack(wb_ack),
    .tri_req(tri_req), .tri_dir(tri_dir), .tri_ack(tri_ack),
    .tri_bit(tri_bit), .tri_cmp(tri_cmp), .tri_taken(tri_taken));

  // payloads {serial[47:0], family[7:0]} in expected enumeration order, with expected fam_disc
  localparam logic [55:0] TBL_ID [4] = '{56'h000000000005_10, 56'h000000000002_28,
                                         56'h000000000001_28, 56'h0000000000A3_28};
  localparam int TBL_FAM [4] = '{4, 4, 4, 4};

  function automatic logic [63:0] mk(input logic [55:0] p);
    logic [7:0] c = 8'h00;
    for (int j = 0; j < 7; j++) begin
      c = c ^ p[8*j +: 8];
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 8'h8C) : (c >> 1);
    end
    return {c, p};
  endfunction

  logic [63:0] devs [5];
  logic [4:0]  en = '0, alive = '0;
  bit          ghost = 0;

  int rst_tot = 0, wb_tot = 0, tri_tot = 0, wb_bad = 0, early_tri = 0;
  int done_tot = 0, dbl_done = 0, tri_idx = 0, wb_since = 0;
  bit prev_done = 0;
  logic [63:0] dirs = '0, res_id = '0;
  logic        res_ok = 0;
  logic [6:0]  res_fam = '0;

  always @(negedge clk) begin
    if (srch_done) begin
      res_id = rom_id; res_ok = srch_ok; res_fam = fam_disc;
      if (prev_done) dbl_done++;
      done_tot++;
    end
    prev_done = srch_done;
    if (brst_ack || wb_ack || tri_ack) begin
      brst_ack = 0; wb_ack = 0; tri_ack = 0;
    end else if (brst_req) begin
      rst_tot++; alive = en; tri_idx = 0; wb_since = 0;
      brst_presence = (en != 0) || ghost; brst_ack = 1;
    end else if (wb_req) begin
      wb_tot++; wb_since++;
      if (wb_data != 8'hF0) wb_bad++;
      wb_ack = 1;
    end else if (tri_req) begin
      logic b, c, t;
      b = 1; c = 1;
      if (wb_since == 0) early_tri++;
      for (int k = 0; k < 5; k++)
        if (alive[k]) begin b &= devs[k][tri_idx[5:0]]; c &= ~devs[k][tri_idx[5:0]]; end
      t = (b != c) ? b : (b ? 1'b1 : tri_dir);
      for (int k = 0; k < 5; k++)
        if (alive[k] && devs[k][tri_idx[5:0]] != t) alive[k] = 0;
      if (tri_idx < 64) dirs[tri_idx[5:0]] = tri_dir;
      tri_bit = b; tri_cmp = c; tri_taken = t;
      tri_idx++; tri_tot++; tri_ack = 1;
    end
  end

  int n_chk = 0, n_bad = 0;
  int d_rst, d_wb, d_tri;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_search();
    int base = done_tot, s_r = rst_tot, s_w = wb_tot, s_t = tri_tot, w = 0;
    @(negedge clk); srch_start = 1;
    @(negedge clk); srch_start = 0;
    while (done_tot == base && w < 3000) begin @(negedge clk); w++; end
    if (done_tot == base) check(0, "R10", "no done", 0, 1);
    d_rst = rst_tot - s_r; d_wb = wb_tot - s_w; d_tri = tri_tot - s_t;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) devs[k] = mk(TBL_ID[k]);
    devs[4] = mk(56'h000000000777_00);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!srch_done && !srch_ok, "R11", "done/ok after reset", {srch_done, srch_ok}, 0);
    check(rom_id == 0 && fam_disc == 0, "R11", "id/fam after reset", rom_id, 0);
    check({brst_req, wb_req, tri_req} == 0, "R11", "requests idle", {brst_req, wb_req, tri_req}, 0);

    en = '0; ghost = 0; run_search();
    check(!res_ok && d_rst == 1 && d_wb == 0 && d_tri == 0, "R1", "empty bus", {res_ok, 8'(d_rst), 8'(d_wb)}, 64'h100);

    ghost = 1; run_search(); ghost = 0;
    check(!res_ok && d_tri == 1, "R4", "no responder abort", {res_ok, 8'(d_tri)}, 1);

    en = 5'b01111;
    for (int i = 0; i < 4; i++) begin
      logic [63:0] prev = res_id;
      run_search();
      check(res_ok == 1, "R7", "search ok", res_ok, 1);
      check(res_id == mk(TBL_ID[i]), "R6", "identifier order/layout", res_id, mk(TBL_ID[i]));
      check(res_fam == 7'(TBL_FAM[i]), "R5", "family position", res_fam, TBL_FAM[i]);
      check(d_wb == 1 && d_tri == 64 && d_rst == 1, "R2", "one command then 64 triplets", {8'(d_wb), 8'(d_tri)}, 64'h0140);
      if (i == 0) check(dirs == 0, "R3", "fresh search dirs all zero", dirs, 0);
      if (i == 1) check(dirs == {60'd0, 1'b1, prev[2:0]}, "R3", "repeat/one/zero dirs", dirs, {60'd0, 1'b1, prev[2:0]});
    end
    check(wb_bad == 0 && early_tri == 0, "R2", "command value and order", {32'(wb_bad), 32'(early_tri)}, 0);

    run_search();
    check(!res_ok && d_rst == 0 && d_wb == 0 && d_tri == 0, "R9", "final flag blocks bus", {res_ok, 8'(d_rst), 8'(d_tri)}, 0);
    check(res_fam == 0, "R9", "state cleared", res_fam, 0);
    run_search();
    check(res_ok && res_id == mk(TBL_ID[0]), "R9", "restart enumeration", res_id, mk(TBL_ID[0]));

    en = 5'b10000; run_search();
    check(!res_ok && d_tri == 64, "R8", "zero family rejected", {res_ok, 8'(d_tri)}, 64);
    check(res_fam == 0, "R8", "fam cleared", res_fam, 0);
    en = 5'b01111; run_search();
    check(res_ok && res_id == mk(TBL_ID[0]) && res_fam == 4, "R8", "fresh after zero family", res_id, mk(TBL_ID[0]));

    devs[4] = mk(56'h0000000000C4_33) ^ 64'h0100_0000_0000_0000;
    en = 5'b10000; run_search();
    check(!res_ok && d_tri == 64, "R7", "bad crc rejected", {res_ok, 8'(d_tri)}, 64);

    check(dbl_done == 0, "R10", "done one cycle", dbl_done, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule